// File: doc/BRIEF.md
# Hot-Plug Slot Fault Supervisor

This block is the digital control core of one hot-plug slot channel. A chip with two slots uses two copies. It switches four main rails (+3.3 V, +5 V, +12 V, −12 V) as one group from a main enable, and the auxiliary rail from its own enable. Analog comparators watch the rails, and their overcurrent and undervoltage verdicts arrive here as asynchronous flags. The block synchronizes them, holds each one for a programmable qualification time, and then latches the fault. A latched fault shuts down every rail of the channel. The other channel is not affected.

Each of the two fault paths (main group, auxiliary rail) has its own latch and its own active-low fault output. A latch is released by toggling the enable of its own path low and then high. While the supply-good flag is false, the block holds everything off and clears both latches. Undervoltage verdicts are blanked until soft start has completed. When both paths are faulting at once, the qualification window is halved so that the channel shuts down faster.

Top module: `hp_slot_supervisor`

## Requirements
- R1: A latched fault on either path turns off all five rail enables in the same clock edge that sets the latch. The fault output of that path goes low. The fault output of a path that is not faulting stays high.
- R2: While no fault is latched, `main_en_i` high drives all four bits of `main_rail_en_o` high together, and low drives them all low. `aux_rail_en_o` follows `aux_en_i` independently.
- R3: A latch stays set while its enable stays high, and toggling the other path's enable does not clear it. It clears only at the first clock edge where its own enable is high, after that enable was sampled low on an edge while the latch was set. The rails come back on at that same edge.
- R4: While `supply_ok_i` is low, all rail enables are low after the next edge, undervoltage flags are ignored, and both latches are cleared.
- R5: When `supply_ok_i` rises with both enables already high, all five rail enables go high together on the next clock edge.
- R6: Undervoltage flags are ignored until `ramp_done_i` is high. This input is registered, so blanking ends one edge after it rises. Overcurrent flags are honoured whenever the rails are on, whatever the state of `ramp_done_i`.
- R7: A fault input held high for QUAL_CYCLES consecutive rising edges latches, and the rails drop at the (QUAL_CYCLES+2)-th edge after it rose. This count includes the SYNC_STAGES=2 synchronizer. A fault input held for only QUAL_CYCLES−1 edges does not latch.
- R8: When the main and auxiliary paths fault together, the window becomes max(1, QUAL_CYCLES/2), and the rails drop at edge max(1, QUAL_CYCLES/2)+2.
- R9: A path's fault output goes low while its synchronized fault is being qualified. It returns high when the fault clears without latching.
- R10: Overcurrent is sensed on all five rails. `main_oc_i` bit order is [0] +3.3 V, [1] +5 V, [2] +12 V, [3] −12 V. Undervoltage is sensed on +3.3 V, +5 V, +12 V (`main_uv_i` [0],[1],[2]) and on the auxiliary rail, but not on −12 V.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| supply_ok_i | input | 1 | Supply good; low inhibits everything |
| ramp_done_i | input | 1 | Soft start complete; enables undervoltage checks |
| main_en_i | input | 1 | Main rail group enable |
| aux_en_i | input | 1 | Auxiliary rail enable |
| main_oc_i | input | 4 | Overcurrent flags, main rails (async) |
| main_uv_i | input | 3 | Undervoltage flags, +3.3/+5/+12 V (async) |
| aux_oc_i | input | 1 | Auxiliary overcurrent flag (async) |
| aux_uv_i | input | 1 | Auxiliary undervoltage flag (async) |
| main_rail_en_o | output | 4 | Main rail enables, same bit order as main_oc_i |
| aux_rail_en_o | output | 1 | Auxiliary rail enable |
| main_fault_no | output | 1 | Main path fault, active low |
| aux_fault_no | output | 1 | Auxiliary path fault, active low |

## Verification
The bench builds the block with QUAL_CYCLES=6 and SYNC_STAGES=2. This makes the full window (shutdown at edge 8) and the halved window (shutdown at edge 5) fall on different cycles, so a missing or wrong halving shows up. The value 6 also leaves room for a five-edge pulse that must be rejected without latching. With the window short, the bench can also cover the re-arm sequences, the supply-drop clear and the blanking cases within a few hundred cycles.

// File: rtl/hp_sup_pkg.sv
package hp_sup_pkg;
  localparam int NUM_MAIN  = 4;  // +3V3, +5V, +12V, -12V
  localparam int NUM_UV    = 3;  // -12V has no undervoltage sense
  localparam int NUM_PATHS = 2;
  localparam int PATH_MAIN = 0;
  localparam int PATH_AUX  = 1;

  typedef enum int {
    RAIL_P3V3 = 0,
    RAIL_P5V0 = 1,
    RAIL_P12V = 2,
    RAIL_N12V = 3
  } main_rail_e;

  function automatic int half_window(input int full);
    return (full / 2 < 1) ? 1 : full / 2;
  endfunction
endpackage

// File: rtl/hp_sync.sv
module hp_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/hp_qual_timer.sv
module hp_qual_timer
  import hp_sup_pkg::*;
#(
  parameter int QUAL_CYCLES = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic main_flag_i,
  input  logic aux_flag_i,
  output logic fire_o
);
  localparam int FULL = (QUAL_CYCLES < 1) ? 1 : QUAL_CYCLES;
  localparam int HALF = half_window(FULL);
  localparam int CW   = $clog2(FULL + 1);

  logic          any_flag, both_flag;
  logic [CW-1:0] cnt_q, limit;

  assign any_flag  = main_flag_i | aux_flag_i;
  assign both_flag = main_flag_i & aux_flag_i;
  assign limit     = both_flag ? CW'(HALF - 1) : CW'(FULL - 1);
  assign fire_o    = any_flag && (cnt_q >= limit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!any_flag || fire_o) cnt_q <= '0;
    else                         cnt_q <= cnt_q + 1'b1;
  end

  generate
    if (FULL > 1) begin : g_hold_chk
      AST_FIRE_NEEDS_HISTORY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fire_o && !both_flag) |-> $past(any_flag)); // R7
    end
  endgenerate
endmodule

// File: rtl/hp_path_latch.sv
module hp_path_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_clr_i,
  input  logic set_i,
  input  logic en_i,
  output logic latch_q_o,
  output logic latch_d_o
);
  logic latch_q, en_q, seen_low_q;
  logic rearm, latch_d, seen_low_d;

  assign rearm      = latch_q & seen_low_q & en_i & ~en_q;
  assign latch_d    = hold_clr_i ? 1'b0 :
                      set_i      ? 1'b1 :
                      rearm      ? 1'b0 : latch_q;
  // enable must be seen low on an edge after the latch is already set
  assign seen_low_d = latch_d & latch_q & (seen_low_q | ~en_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_q    <= 1'b0;
      en_q       <= 1'b0;
      seen_low_q <= 1'b0;
    end else begin
      latch_q    <= latch_d;
      en_q       <= en_i;
      seen_low_q <= seen_low_d;
    end
  end

  assign latch_q_o = latch_q;
  assign latch_d_o = latch_d;

  AST_CLEAR_NEEDS_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(latch_q) && !$past(hold_clr_i)) |-> ($past(en_i) && $past(seen_low_q))); // R3
endmodule

// File: rtl/hp_slot_supervisor.sv
module hp_slot_supervisor
  import hp_sup_pkg::*;
#(
  parameter int QUAL_CYCLES = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                supply_ok_i,
  input  logic                ramp_done_i,
  input  logic                main_en_i,
  input  logic                aux_en_i,
  input  logic [NUM_MAIN-1:0] main_oc_i,
  input  logic [NUM_UV-1:0]   main_uv_i,
  input  logic                aux_oc_i,
  input  logic                aux_uv_i,
  output logic [NUM_MAIN-1:0] main_rail_en_o,
  output logic                aux_rail_en_o,
  output logic                main_fault_no,
  output logic                aux_fault_no
);
  localparam int SW     = NUM_MAIN + NUM_UV + 2;
  localparam int AOC_IX = NUM_MAIN + NUM_UV;
  localparam int AUV_IX = SW - 1;

  logic [SW-1:0]        raw_flags, sync_flags;
  logic [NUM_MAIN-1:0]  main_oc_s;
  logic [NUM_UV-1:0]    main_uv_s;
  logic                 aux_oc_s, aux_uv_s;
  logic                 uv_en_q, main_on_q, aux_on_q, fire, any_latch_d;
  logic [NUM_PATHS-1:0] path_flag, path_en, path_on, latch_q, latch_d;

  assign raw_flags = {aux_uv_i, aux_oc_i, main_uv_i, main_oc_i};

  hp_sync #(.WIDTH(SW), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw_flags),
    .q_o   (sync_flags)
  );

  assign main_oc_s = sync_flags[NUM_MAIN-1:0];
  assign main_uv_s = sync_flags[NUM_MAIN +: NUM_UV];
  assign aux_oc_s  = sync_flags[AOC_IX];
  assign aux_uv_s  = sync_flags[AUV_IX];

  // faults only count on rails that are actually on
  assign path_on[PATH_MAIN]   = main_on_q;
  assign path_on[PATH_AUX]    = aux_on_q;
  assign path_en[PATH_MAIN]   = main_en_i;
  assign path_en[PATH_AUX]    = aux_en_i;
  assign path_flag[PATH_MAIN] = main_on_q & ((|main_oc_s) | (uv_en_q & (|main_uv_s)));
  assign path_flag[PATH_AUX]  = aux_on_q  & (aux_oc_s | (uv_en_q & aux_uv_s));

  hp_qual_timer #(.QUAL_CYCLES(QUAL_CYCLES)) i_qual (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .main_flag_i(path_flag[PATH_MAIN]),
    .aux_flag_i (path_flag[PATH_AUX]),
    .fire_o     (fire)
  );

  for (genvar p = 0; p < NUM_PATHS; p++) begin : g_path
    hp_path_latch i_latch (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .hold_clr_i(~supply_ok_i),
      .set_i     (fire & path_flag[p]),
      .en_i      (path_en[p]),
      .latch_q_o (latch_q[p]),
      .latch_d_o (latch_d[p])
    );
  end

  assign any_latch_d = |latch_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      uv_en_q   <= 1'b0;
      main_on_q <= 1'b0;
      aux_on_q  <= 1'b0;
    end else begin
      uv_en_q   <= supply_ok_i & ramp_done_i;
      main_on_q <= supply_ok_i & main_en_i & ~any_latch_d;
      aux_on_q  <= supply_ok_i & aux_en_i  & ~any_latch_d;
    end
  end

  assign main_rail_en_o = {NUM_MAIN{main_on_q}};
  assign aux_rail_en_o  = aux_on_q;
  assign main_fault_no  = ~(path_flag[PATH_MAIN] | latch_q[PATH_MAIN]);
  assign aux_fault_no   = ~(path_flag[PATH_AUX]  | latch_q[PATH_AUX]);

  AST_RAILS_GROUPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (main_rail_en_o == '0) || (main_rail_en_o == '1)); // R2
  AST_LATCH_SHUTS_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|latch_q) |-> (!main_on_q && !aux_on_q && (path_on == '0))); // R1
  AST_NO_SUPPLY_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !supply_ok_i |=> (!main_on_q && !aux_on_q && (latch_q == '0))); // R4
  AST_UV_NEEDS_SUPPLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uv_en_q |-> $past(supply_ok_i && ramp_done_i)); // R6
endmodule

// File: tb/test_hp_slot_supervisor.sv
`timescale 1ns/1ps
module test_hp_slot_supervisor;
  localparam int QUAL = 6;
  localparam int HALF = 3;

  typedef struct {
    string      tag;
    logic [3:0] main_en;
    logic       aux_en;
    logic       fm_n;
    logic       fa_n;
  } exp_t;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic supply_ok = 0, ramp_done = 0, main_en = 0, aux_en = 0;
  logic [3:0] main_oc = '0;
  logic [2:0] main_uv = '0;
  logic aux_oc = 0, aux_uv = 0;
  logic [3:0] main_rail_en;
  logic aux_rail_en, main_fault_n, aux_fault_n;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  exp_t sb_q[$];

  always #5 clk = ~clk;

  hp_slot_supervisor #(.QUAL_CYCLES(QUAL), .SYNC_STAGES(2)) i_hp_slot_supervisor (
    .clk_i(clk), .rst_ni(rst_ni), .supply_ok_i(supply_ok), .ramp_done_i(ramp_done),
    .main_en_i(main_en), .aux_en_i(aux_en), .main_oc_i(main_oc), .main_uv_i(main_uv),
    .aux_oc_i(aux_oc), .aux_uv_i(aux_uv), .main_rail_en_o(main_rail_en),
    .aux_rail_en_o(aux_rail_en), .main_fault_no(main_fault_n), .aux_fault_no(aux_fault_n)
  );

  // monitor: compares queued expectations with the ports between edges
  always @(negedge clk) begin
    #2;
    while (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      n_cmp++;
      if (main_rail_en !== e.main_en || aux_rail_en !== e.aux_en ||
          main_fault_n !== e.fm_n || aux_fault_n !== e.fa_n) begin
        n_bad++;
        $display("FAIL %s: got main=%h aux=%b fm_n=%b fa_n=%b, exp main=%h aux=%b fm_n=%b fa_n=%b",
                 e.tag, main_rail_en, aux_rail_en, main_fault_n, aux_fault_n,
                 e.main_en, e.aux_en, e.fm_n, e.fa_n);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
    #1;
  endtask

  task automatic expect_st(input string tag, input logic [3:0] m, input logic a,
                           input logic fm, input logic fa);
    exp_t e;
    e.tag = tag; e.main_en = m; e.aux_en = a; e.fm_n = fm; e.fa_n = fa;
    sb_q.push_back(e);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got running, exp finished");
      finish_run();
    end
  end

  initial begin
    tick(2);
    expect_st("R4 reset state", 4'h0, 0, 1, 1);
    tick(1);
    rst_ni = 1;
    main_en = 1; aux_en = 1; main_uv = 3'b111;
    tick(6);
    expect_st("R4 no supply: off, uv ignored", 4'h0, 0, 1, 1);
    main_uv = '0; supply_ok = 1;
    tick(1);
    expect_st("R5 all five on together", 4'hF, 1, 1, 1);

    // undervoltage blanking before soft start completes
    main_uv[1] = 1;
    tick(12);
    expect_st("R6 uv blanked while ramping", 4'hF, 1, 1, 1);
    ramp_done = 1;
    tick(1);
    expect_st("R9 main fault low while qualifying", 4'hF, 1, 0, 1);
    tick(QUAL - 1);
    expect_st("R7 not yet latched", 4'hF, 1, 0, 1);
    tick(1);
    expect_st("R1 uv latch kills all rails", 4'h0, 0, 0, 1);
    main_uv = '0;
    tick(10);
    expect_st("R3 latch holds with enable high", 4'h0, 0, 0, 1);
    aux_en = 0; tick(2); aux_en = 1; tick(2);
    expect_st("R3 aux toggle leaves main latch", 4'h0, 0, 0, 1);
    main_en = 0; tick(1); main_en = 1; tick(1);
    expect_st("R3 main toggle re-arms", 4'hF, 1, 1, 1);

    main_en = 0; tick(1);
    expect_st("R2 main off, aux independent", 4'h0, 1, 1, 1);
    main_en = 1; tick(1);
    expect_st("R2 main group on", 4'hF, 1, 1, 1);

    // short pulse on -12V overcurrent
    main_oc[3] = 1;
    tick(3);
    expect_st("R10 -12V oc seen, R9 low", 4'hF, 1, 0, 1);
    tick(QUAL - 4);
    main_oc[3] = 0;
    tick(4);
    expect_st("R7 short pulse rejected, R9 high again", 4'hF, 1, 1, 1);

    // auxiliary overcurrent, full window
    aux_oc = 1;
    tick(QUAL + 1);
    expect_st("R7 aux edge before shutdown", 4'hF, 1, 1, 0);
    tick(1);
    expect_st("R1 aux fault kills main too", 4'h0, 0, 1, 0);
    aux_oc = 0;
    main_en = 0; tick(1); main_en = 1; tick(2);
    expect_st("R3 main toggle leaves aux latch", 4'h0, 0, 1, 0);
    aux_en = 0; tick(1); aux_en = 1; tick(1);
    expect_st("R3 aux toggle re-arms", 4'hF, 1, 1, 1);

    // both paths at once: halved window
    main_oc[1] = 1; aux_oc = 1;
    tick(HALF + 1);
    expect_st("R8 halved, not yet", 4'hF, 1, 0, 0);
    tick(1);
    expect_st("R8 halved shutdown", 4'h0, 0, 0, 0);
    main_oc = '0; aux_oc = 0;

    supply_ok = 0;
    tick(2);
    expect_st("R4 supply loss clears latches", 4'h0, 0, 1, 1);
    supply_ok = 1;
    tick(1);
    expect_st("R5 restore with enables high", 4'hF, 1, 1, 1);

    // overcurrent honoured during soft start
    ramp_done = 0; tick(1);
    main_oc[2] = 1;
    tick(QUAL + 1);
    expect_st("R6 oc during ramp qualifying", 4'hF, 1, 0, 1);
    tick(1);
    expect_st("R6 oc during ramp latched", 4'h0, 0, 0, 1);
    main_oc = '0;
    main_en = 0; tick(1); main_en = 1; ramp_done = 1; tick(2);
    expect_st("R3 re-armed after ramp oc", 4'hF, 1, 1, 1);

    aux_uv = 1;
    tick(QUAL + 2);
    expect_st("R10 aux undervoltage latches", 4'h0, 0, 1, 0);
    aux_uv = 0;

    tick(2);
    done = 1;
    finish_run();
  end
endmodule